// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block gives software a view of how often a set of hardware conditions occur. It holds a bank of wide counters. Each counter watches one line of an event vector, picked by an 8-bit selection code, and adds one on every clock in which that line is high. The selection code zero is special: it counts every clock, whatever the event lines do.

Software reaches the monitor through a 32-bit register bus with an address, write data, a write strobe and a read strobe. Through that bus it picks events, arms counters through a global switch and per-counter switches, presets or reads back counter values, and services overflow interrupts. A counter that wraps past its top value raises a sticky status bit. That bit drives one interrupt line unless it is masked, and software clears it with a write-one-to-clear register. A read-only identifier word and a power-management hold bit complete the map. The hold bit is brought out as a pin, and software keeps it set while it uses the monitor.

Top module: `evt_perf_mon`

## Requirements
- R1: After reset every readable register reads zero except the identifier word, and `irq_o` and `pm_off_o` are low.
- R2: Counter n (n = 0..7) is readable and writable as a low word at 0x1D00 + 8*n and a high word at 0x1D04 + 8*n. A write replaces only the addressed half.
- R3: A counter changes by counting only when bit 0 of 0x1C00 and bit n of 0x1C04 are both 1. It then adds exactly one for each clock in which its selected event is high.
- R4: Counters 0..3 take their code from the word at 0x1C80 and counters 4..7 from the word at 0x1C84, using bits [8*(n%4)+7 : 8*(n%4)]. A code k other than 0 selects `evt_i[k]`, and code 0x00 counts every clock.
- R5: When a counting counter goes from all ones to zero, status bit n at 0x1C78 becomes 1 on the same clock edge. A status bit never sets for any other reason.
- R6: Writing 1 to bit n of 0x1C7C clears status bit n, and 0 bits leave it unchanged. A wrap in the same cycle wins, so the bit stays set.
- R7: `irq_o` is 1 exactly when some status bit is 1 and its bit in the mask register 0x1C70 is 0. A mask bit of 1 hides that counter.
- R8: A bus write to either half of a counter takes priority over a count in the same cycle. The counter then holds the written value, and no wrap is recorded.
- R9: Reads of unmapped or non-word-aligned offsets return zero. The word at 0x1CF0 always returns the `VERSION_ID` parameter, and writes to it are ignored.
- R10: Bit 9 of 0x0534 is readable and writable and drives `pm_off_o`. The other bits of that word read zero.
- R11: `rdata_o` is registered. It shows the addressed word on the clock after a cycle with `rd_i` high, and holds its value in every cycle without `rd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| evt_i | input | 256 | Event lines; line k is selected by code k |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Overflow interrupt, active high |
| pm_off_o | output | 1 | Power-management hold, mirrors the config bit |

## Verification
The properties assume that the bus carries at most one access per cycle. They also assume that the strobes and address are stable and known around each rising edge. The bench drives every input on the falling edge, one write or one read per cycle, so these assumptions always hold. The event vector is not constrained, since any pattern of lines is legal; random patterns are applied while random register traffic, including counter presets, clears and mask changes, runs against a behavioural model. The wrap-versus-clear collision is set up on purpose by presetting a counter to all ones just before a clear.

// File: rtl/epm_pkg.sv
package epm_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 16;
  localparam int CODE_W = 8;
  localparam int CODES_PER_WORD = BUS_W / CODE_W;
  localparam int CTR_STRIDE = 8;

  // register offsets; the counter window and select words are decoded by index
  localparam logic [ADDR_W-1:0] A_CTRL     = 16'h1C00;
  localparam logic [ADDR_W-1:0] A_CTR_EN   = 16'h1C04;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 16'h1C70;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 16'h1C78;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 16'h1C7C;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 16'h1C80;
  localparam logic [ADDR_W-1:0] A_VERSION  = 16'h1CF0;
  localparam logic [ADDR_W-1:0] A_CTR_BASE = 16'h1D00;
  localparam logic [ADDR_W-1:0] A_PWR_CFG  = 16'h0534;

  localparam int GLB_BIT = 0;
  localparam int PWR_BIT = 9;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;
  } bus_req_t;

endpackage

// File: rtl/epm_counter.sv
module epm_counter
  import epm_pkg::*;
#(
  parameter int CTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CTR_W-1:0] val_o,
  output logic             wrap_o
);

  localparam int HI_W = CTR_W - BUS_W;

  logic [CTR_W-1:0] cnt_q;
  logic             sw_write;

  function automatic logic at_top(logic [CTR_W-1:0] v);
    return &v;
  endfunction

  assign sw_write = wr_lo_i | wr_hi_i;
  // a wrap is only recorded when the count really happens
  assign wrap_o   = inc_i & ~sw_write & at_top(cnt_q);
  assign val_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sw_write) begin
      if (wr_lo_i) cnt_q[BUS_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CTR_W-1:BUS_W] <= wdata_i[HI_W-1:0];
    end else if (inc_i) begin
      cnt_q <= cnt_q + CTR_W'(1);
    end
  end

endmodule

// File: rtl/epm_irq_ctl.sv
module epm_irq_ctl #(
  parameter int NUM_CTR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTR-1:0] wrap_i,
  input  logic [NUM_CTR-1:0] clr_i,
  input  logic [NUM_CTR-1:0] mask_i,
  output logic [NUM_CTR-1:0] stat_o,
  output logic               irq_o
);

  logic [NUM_CTR-1:0] stat_q;

  function automatic logic [NUM_CTR-1:0] next_stat(logic [NUM_CTR-1:0] cur,
                                                  logic [NUM_CTR-1:0] clr,
                                                  logic [NUM_CTR-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= next_stat(stat_q, clr_i, wrap_i);
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i);

endmodule

// File: rtl/epm_regfile.sv
module epm_regfile
  import epm_pkg::*;
#(
  parameter int          NUM_CTR    = 8,
  parameter int          CTR_W      = 64,
  parameter logic [31:0] VERSION_ID = 32'h0001_0200
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  bus_req_t                      req_i,
  input  logic [NUM_CTR*CTR_W-1:0]      ctr_val_i,
  input  logic [NUM_CTR-1:0]            stat_i,
  output logic                          glb_en_o,
  output logic [NUM_CTR-1:0]            ctr_en_o,
  output logic [NUM_CTR-1:0]            mask_o,
  output logic [SEL_WORDS*BUS_W-1:0]    sel_flat_o,
  output logic                          pm_off_o,
  output logic [NUM_CTR-1:0]            ctr_wr_lo_o,
  output logic [NUM_CTR-1:0]            ctr_wr_hi_o,
  output logic [NUM_CTR-1:0]            clr_o,
  output logic [BUS_W-1:0]              rdata_o
);

  localparam int SEL_WORDS = (NUM_CTR + CODES_PER_WORD - 1) / CODES_PER_WORD;
  localparam int HI_W      = CTR_W - BUS_W;
  localparam logic [ADDR_W-1:0] CTR_END = A_CTR_BASE + ADDR_W'(NUM_CTR * CTR_STRIDE);

  logic                       glb_q;
  logic [NUM_CTR-1:0]         en_q;
  logic [NUM_CTR-1:0]         mask_q;
  logic [SEL_WORDS*BUS_W-1:0] sel_q;
  logic                       pm_q;
  logic [BUS_W-1:0]           rdata_q;
  logic [BUS_W-1:0]           rd_next;

  function automatic logic in_ctr_window(logic [ADDR_W-1:0] a);
    return (a >= A_CTR_BASE) && (a < CTR_END) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [ADDR_W-1:0] ctr_lo_addr(int n);
    return A_CTR_BASE + ADDR_W'(n * CTR_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] sel_addr(int k);
    return A_SEL_BASE + ADDR_W'(k * 4);
  endfunction

  // per-counter write strobes
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_wr
    assign ctr_wr_lo_o[n] = req_i.wr && (req_i.addr == ctr_lo_addr(n));
    assign ctr_wr_hi_o[n] = req_i.wr && (req_i.addr == ctr_lo_addr(n) + ADDR_W'(4));
  end

  assign clr_o = (req_i.wr && req_i.addr == A_IRQ_CLR) ? req_i.wdata[NUM_CTR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '0;
      sel_q  <= '0;
      pm_q   <= 1'b0;
    end else if (req_i.wr) begin
      case (req_i.addr)
        A_CTRL:     glb_q  <= req_i.wdata[GLB_BIT];
        A_CTR_EN:   en_q   <= req_i.wdata[NUM_CTR-1:0];
        A_IRQ_MASK: mask_q <= req_i.wdata[NUM_CTR-1:0];
        A_PWR_CFG:  pm_q   <= req_i.wdata[PWR_BIT];
        default:    ;
      endcase
      for (int k = 0; k < SEL_WORDS; k++) begin
        if (req_i.addr == sel_addr(k)) sel_q[k*BUS_W +: BUS_W] <= req_i.wdata;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (req_i.addr)
      A_CTRL:     rd_next[GLB_BIT] = glb_q;
      A_CTR_EN:   rd_next = BUS_W'(en_q);
      A_IRQ_MASK: rd_next = BUS_W'(mask_q);
      A_IRQ_STAT: rd_next = BUS_W'(stat_i);
      A_VERSION:  rd_next = VERSION_ID;
      A_PWR_CFG:  rd_next[PWR_BIT] = pm_q;
      default:    ;
    endcase
    for (int k = 0; k < SEL_WORDS; k++) begin
      if (req_i.addr == sel_addr(k)) rd_next = sel_q[k*BUS_W +: BUS_W];
    end
    if (in_ctr_window(req_i.addr)) begin
      for (int n = 0; n < NUM_CTR; n++) begin
        if (req_i.addr == ctr_lo_addr(n))
          rd_next = ctr_val_i[n*CTR_W +: BUS_W];
        if (req_i.addr == ctr_lo_addr(n) + ADDR_W'(4))
          rd_next = BUS_W'(ctr_val_i[n*CTR_W+BUS_W +: HI_W]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (req_i.rd) rdata_q <= rd_next;
  end

  assign glb_en_o   = glb_q;
  assign ctr_en_o   = en_q;
  assign mask_o     = mask_q;
  assign sel_flat_o = sel_q;
  assign pm_off_o   = pm_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/evt_perf_mon.sv
module evt_perf_mon
  import epm_pkg::*;
#(
  parameter int          NUM_CTR    = 8,
  parameter int          CTR_W      = 64,
  parameter logic [31:0] VERSION_ID = 32'h0001_0200
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BUS_W-1:0]       wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [(1<<CODE_W)-1:0] evt_i,
  output logic [BUS_W-1:0]       rdata_o,
  output logic                   irq_o,
  output logic                   pm_off_o
);

  localparam int NUM_EVT   = 1 << CODE_W;
  localparam int SEL_WORDS = (NUM_CTR + CODES_PER_WORD - 1) / CODES_PER_WORD;

  bus_req_t                   req;
  logic                       glb_en;
  logic [NUM_CTR-1:0]         ctr_en;
  logic [NUM_CTR-1:0]         mask;
  logic [SEL_WORDS*BUS_W-1:0] sel_flat;
  logic [NUM_CTR-1:0]         ctr_wr_lo;
  logic [NUM_CTR-1:0]         ctr_wr_hi;
  logic [NUM_CTR-1:0]         clr;
  logic [NUM_CTR-1:0]         inc;
  logic [NUM_CTR-1:0]         wrap;
  logic [NUM_CTR-1:0]         stat;
  logic [NUM_CTR*CTR_W-1:0]   ctr_flat;

  // code zero means "every clock"; any other code picks its event line
  function automatic logic evt_hit(logic [CODE_W-1:0] code, logic [NUM_EVT-1:0] ev);
    return (code == '0) ? 1'b1 : ev[code];
  endfunction

  assign req = '{wr: wr_i, rd: rd_i, addr: addr_i, wdata: wdata_i};

  epm_regfile #(
    .NUM_CTR   (NUM_CTR),
    .CTR_W     (CTR_W),
    .VERSION_ID(VERSION_ID)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .ctr_val_i  (ctr_flat),
    .stat_i     (stat),
    .glb_en_o   (glb_en),
    .ctr_en_o   (ctr_en),
    .mask_o     (mask),
    .sel_flat_o (sel_flat),
    .pm_off_o   (pm_off_o),
    .ctr_wr_lo_o(ctr_wr_lo),
    .ctr_wr_hi_o(ctr_wr_hi),
    .clr_o      (clr),
    .rdata_o    (rdata_o)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic [CODE_W-1:0] code;
    assign code   = sel_flat[n*CODE_W +: CODE_W];
    assign inc[n] = glb_en & ctr_en[n] & evt_hit(code, evt_i);

    epm_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(ctr_wr_lo[n]),
      .wr_hi_i(ctr_wr_hi[n]),
      .wdata_i(wdata_i),
      .inc_i  (inc[n]),
      .val_o  (ctr_flat[n*CTR_W +: CTR_W]),
      .wrap_o (wrap[n])
    );
  end

  epm_irq_ctl #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_i(wrap),
    .clr_i (clr),
    .mask_i(mask),
    .stat_o(stat),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/epm_checker.sv
module epm_checker #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     glb_en,
  input logic [NUM_CTR-1:0]       wr_lo,
  input logic [NUM_CTR-1:0]       wr_hi,
  input logic [NUM_CTR*CTR_W-1:0] ctr_flat,
  input logic [NUM_CTR-1:0]       wrap,
  input logic [NUM_CTR-1:0]       stat,
  input logic [NUM_CTR-1:0]       mask,
  input logic [NUM_CTR-1:0]       clr,
  input logic                     irq_o,
  input logic                     rd_i,
  input logic [31:0]              rdata_o
);

  p_hold_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en && wr_lo == '0 && wr_hi == '0) |=> $stable(ctr_flat));

  p_wrap_sets_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap != '0) |=> ((stat & $past(wrap)) == $past(wrap)));

  p_status_needs_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat & ~$past(stat) & ~$past(wrap)) == '0);

  p_clear_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr != '0) |=> ((stat & $past(clr) & ~$past(wrap)) == '0));

  p_all_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> !irq_o);

  p_irq_has_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat != '0));

  p_no_wrap_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wrap & (wr_lo | wr_hi)) == '0));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

endmodule

bind evt_perf_mon epm_checker #(
  .NUM_CTR(NUM_CTR),
  .CTR_W  (CTR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .glb_en  (glb_en),
  .wr_lo   (ctr_wr_lo),
  .wr_hi   (ctr_wr_hi),
  .ctr_flat(ctr_flat),
  .wrap    (wrap),
  .stat    (stat),
  .mask    (mask),
  .clr     (clr),
  .irq_o   (irq_o),
  .rd_i    (rd_i),
  .rdata_o (rdata_o)
);

// File: tb/test_evt_perf_mon.sv
`timescale 1ns/1ps
module test_evt_perf_mon;

  localparam logic [31:0] VER = 32'h0001_0200;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic         wr_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [255:0] evt_i = '0;
  logic [31:0]  rdata_o;
  logic         irq_o;
  logic         pm_off_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_perf_mon #(.VERSION_ID(VER)) i_evt_perf_mon (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .evt_i(evt_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .pm_off_o(pm_off_o)
  );

  // behavioural reference state
  logic [63:0] m_cnt [8];
  logic        m_glb = 0;
  logic [7:0]  m_en = 0, m_mask = 0, m_stat = 0;
  logic [31:0] m_sel [2];
  logic        m_pm = 0;
  logic [31:0] m_rd = 0;

  function automatic logic [31:0] m_read(logic [15:0] a);
    if (a == 16'h1C00) return {31'b0, m_glb};
    if (a == 16'h1C04) return {24'b0, m_en};
    if (a == 16'h1C70) return {24'b0, m_mask};
    if (a == 16'h1C78) return {24'b0, m_stat};
    if (a == 16'h1C80) return m_sel[0];
    if (a == 16'h1C84) return m_sel[1];
    if (a == 16'h1CF0) return VER;
    if (a == 16'h0534) return m_pm ? 32'h200 : 32'h0;
    for (int n = 0; n < 8; n++) begin
      if (a == 16'h1D00 + 16'(8*n)) return m_cnt[n][31:0];
      if (a == 16'h1D04 + 16'(8*n)) return m_cnt[n][63:32];
    end
    return 32'h0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [15:0] a, logic [31:0] d,
                     logic [255:0] ev, string tag);
    logic [31:0] rv;
    logic [7:0]  wraps;
    logic [7:0]  code;
    bit          hit;
    wr_i = wr; rd_i = rd; addr_i = a; wdata_i = d; evt_i = ev;
    rv = m_read(a);
    wraps = '0;
    for (int n = 0; n < 8; n++) begin
      code = m_sel[n/4][8*(n%4) +: 8];
      hit = (code == 8'h00) || ev[code];
      if (wr && a == 16'h1D00 + 16'(8*n))      m_cnt[n][31:0]  = d;
      else if (wr && a == 16'h1D04 + 16'(8*n)) m_cnt[n][63:32] = d;
      else if (m_glb && m_en[n] && hit) begin
        if (m_cnt[n] == '1) wraps[n] = 1'b1;
        m_cnt[n] = m_cnt[n] + 64'd1;
      end
    end
    if (wr) begin
      case (a)
        16'h1C00: m_glb  = d[0];
        16'h1C04: m_en   = d[7:0];
        16'h1C70: m_mask = d[7:0];
        16'h1C7C: m_stat = m_stat & ~d[7:0];
        16'h1C80: m_sel[0] = d;
        16'h1C84: m_sel[1] = d;
        16'h0534: m_pm   = d[9];
        default: ;
      endcase
    end
    m_stat = m_stat | wraps;
    if (rd) m_rd = rv;
    @(negedge clk);
    chk(tag, "rdata", rdata_o, m_rd);
    chk("R7", "irq", {31'b0, irq_o}, {31'b0, |(m_stat & ~m_mask)});
    chk("R10", "pm_off", {31'b0, pm_off_o}, {31'b0, m_pm});
  endtask

  task automatic wr32(logic [15:0] a, logic [31:0] d, string tag);
    cyc(1, 0, a, d, '0, tag);
  endtask

  task automatic rd32(logic [15:0] a, string tag);
    cyc(0, 1, a, 32'h0, '0, tag);
  endtask

  task automatic rd_and_expect(logic [15:0] a, logic [31:0] exp, string tag);
    rd32(a, tag);
    chk(tag, "direct", rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) m_cnt[n] = '0;
    m_sel[0] = '0; m_sel[1] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    cyc(0, 0, 16'h0, 32'h0, '0, "R1");
    foreach (m_sel[k]) rd32(16'h1C80 + 16'(4*k), "R1");
    rd32(16'h1C00, "R1"); rd32(16'h1C04, "R1"); rd32(16'h1C70, "R1");
    rd32(16'h1C78, "R1"); rd32(16'h0534, "R1");
    for (int n = 0; n < 8; n++) rd32(16'h1D00 + 16'(8*n), "R1");
    // R9: identifier, writes ignored, unmapped and unaligned reads
    rd_and_expect(16'h1CF0, VER, "R9");
    wr32(16'h1CF0, 32'hDEAD_BEEF, "R9");
    rd_and_expect(16'h1CF0, VER, "R9");
    wr32(16'h1D02, 32'h1234_5678, "R9");
    rd_and_expect(16'h1D02, 32'h0, "R9");
    rd_and_expect(16'h1D40, 32'h0, "R9");
    rd_and_expect(16'h1C08, 32'h0, "R9");
    rd_and_expect(16'h1D00, 32'h0, "R9");

    // R2: halves of a counter
    wr32(16'h1D18, 32'hA5A5_0001, "R2");
    wr32(16'h1D1C, 32'h0000_00C3, "R2");
    rd_and_expect(16'h1D18, 32'hA5A5_0001, "R2");
    rd_and_expect(16'h1D1C, 32'h0000_00C3, "R2");
    wr32(16'h1D18, 32'h0, "R2");
    rd_and_expect(16'h1D1C, 32'h0000_00C3, "R2");

    // R10: power hold bit
    wr32(16'h0534, 32'hFFFF_FFFF, "R10");
    rd_and_expect(16'h0534, 32'h0000_0200, "R10");

    // R4: event codes; R3: local enables without global enable
    wr32(16'h1C80, 32'hE1_62_61_00, "R4");
    wr32(16'h1C84, 32'h07_05_03_E2, "R4");
    wr32(16'h1C04, 32'hFF, "R3");
    for (int i = 0; i < 20; i++) cyc(0, 0, 16'h0, 32'h0, {8{$urandom}}, "R3");
    rd_and_expect(16'h1D00, 32'h0, "R3");
    wr32(16'h1C00, 32'h1, "R3");
    for (int i = 0; i < 40; i++) cyc(0, 0, 16'h0, 32'h0, {8{$urandom}}, "R4");
    wr32(16'h1C00, 32'h0, "R3");
    rd_and_expect(16'h1D00, 32'd41, "R4");
    for (int n = 0; n < 8; n++) rd32(16'h1D00 + 16'(8*n), "R4");
    wr32(16'h1C04, 32'h05, "R3");
    wr32(16'h1C00, 32'h1, "R3");
    for (int i = 0; i < 30; i++) cyc(0, 0, 16'h0, 32'h0, {8{$urandom}}, "R3");
    for (int n = 0; n < 8; n++) rd32(16'h1D00 + 16'(8*n), "R3");

    // R5, R7: wrap of counter 0 (code 0 counts every clock)
    wr32(16'h1C00, 32'h0, "R5");
    wr32(16'h1D00, 32'hFFFF_FFFE, "R5");
    wr32(16'h1D04, 32'hFFFF_FFFF, "R5");
    wr32(16'h1C04, 32'h01, "R5");
    wr32(16'h1C00, 32'h1, "R5");
    cyc(0, 0, 16'h0, 32'h0, '0, "R5");
    cyc(0, 0, 16'h0, 32'h0, '0, "R5");
    chk("R7", "irq after wrap", {31'b0, irq_o}, 32'h1);
    rd_and_expect(16'h1C78, 32'h01, "R5");
    wr32(16'h1C70, 32'h01, "R7");
    chk("R7", "masked irq", {31'b0, irq_o}, 32'h0);
    wr32(16'h1C70, 32'h00, "R7");
    // R6: zero bits ignored, then clear
    wr32(16'h1C7C, 32'hFE, "R6");
    rd_and_expect(16'h1C78, 32'h01, "R6");
    wr32(16'h1C7C, 32'h01, "R6");
    rd_and_expect(16'h1C78, 32'h00, "R6");
    // R8: writes win over counting; R6: wrap wins over clear
    wr32(16'h1D00, 32'hFFFF_FFFF, "R8");
    wr32(16'h1D04, 32'hFFFF_FFFF, "R8");
    wr32(16'h1C7C, 32'h01, "R6");
    chk("R6", "wrap beats clear", {31'b0, irq_o}, 32'h1);
    wr32(16'h1C00, 32'h0, "R8");
    rd_and_expect(16'h1D00, 32'h1, "R8");
    rd_and_expect(16'h1C78, 32'h01, "R6");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int pick;
      pick = $urandom_range(0, 11);
      case (pick)
        0: a = 16'h1C00; 1: a = 16'h1C04; 2: a = 16'h1C70; 3: a = 16'h1C7C;
        4: a = 16'h1C80; 5: a = 16'h1C84; 6: a = 16'h1C78; 7: a = 16'h0534;
        default: a = 16'h1D00 + 16'(4 * $urandom_range(0, 15));
      endcase
      case ($urandom_range(0, 3))
        0: cyc(1, 0, a, (pick >= 8) ? 32'hFFFF_FFF0 | $urandom_range(0, 15) : $urandom,
               {8{$urandom}}, "R4");
        1: cyc(0, 1, a, 32'h0, {8{$urandom}}, "R11");
        default: cyc(0, 0, a, 32'h0, {8{$urandom}}, "R11");
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule